// File: doc/BRIEF.md
# Registered 8-bit Arithmetic and Flag Unit

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle the sequencer may present an operation code with `opValid`. It also presents the accumulator value, a memory operand and the current carry, zero, negative, overflow and decimal flags. On the next clock edge the block registers an 8-bit result and the updated four condition flags. It pulses `doneOut` for that cycle. Single-operand operations (shifts, rotates, increment, decrement) act on `accIn`. The sequencer routes a memory or index value onto that port when the instruction targets one.

Binary and packed-decimal add and subtract share one operand path. A decimal add or subtract also raises `extraOut` alongside `doneOut`. The sequencer uses it to stretch the instruction by one cycle. Compare reuses the subtract path but hands back the accumulator unchanged. Two bit-test operations combine the operand with the accumulator as a mask. They take negative and overflow straight from the operand's two top bits.

Top module: `alu_core`

## Requirements
- R1: While `rstN` is low, `resultOut`, all four flag outputs, `doneOut` and `extraOut` are 0.
- R2: An operation sampled with `opValid` high at a rising edge appears on the outputs after that edge, with `doneOut` high for that cycle. With `opValid` low, `doneOut` is 0 after the edge and result and flags hold their values whatever the other inputs do.
- R3: Code 0 (add) with `dIn`=0 gives A+M+C. C is set when the sum exceeds 255. V is set exactly when A and M share bit 7 and the result's bit 7 differs from A's. Z and N follow the result.
- R4: Code 1 (subtract) with `dIn`=0 gives A−M−(1−C). C=1 means no borrow (A ≥ M+1−C). V follows the two's-complement overflow of the signed subtraction. Z and N follow the result.
- R5: With `dIn`=1, codes 0 and 1 treat both operands as two BCD digits. They produce the corrected BCD result, with C as decimal carry (add) or no-borrow (subtract). Z and N come from the corrected result, and V keeps its incoming value.
- R6: `extraOut` is high, together with `doneOut`, exactly after an add or subtract sampled with `dIn`=1. It is 0 after every other operation or idle cycle.
- R7: Codes 2, 3 and 4 give A AND M, A OR M and A XOR M. Z and N follow the result, and C and V keep their incoming values.
- R8: Code 5 shifts A left with 0 into bit 0. Code 6 shifts right with 0 into bit 7. Code 7 rotates left through carry and code 8 rotates right through carry. In every case C takes the bit shifted out, Z and N follow the result, and V is kept.
- R9: Codes 9 and 10 give A+1 and A−1 modulo 256. Z and N follow the result, and C and V keep their incoming values even on wrap-around.
- R10: Code 11 (compare) returns A unchanged as the result. It sets C when A ≥ M unsigned, sets Z and N from A−M, and keeps V.
- R11: Code 12 gives M AND NOT A and code 13 gives M OR A. Z follows that result, N and V copy bits 7 and 6 of M, and C is kept.
- R12: Codes 14 and 15 return A as the result and pass all four incoming flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code (see requirements) |
| accIn | input | WIDTH (8) | Accumulator or single-operand value |
| memIn | input | WIDTH (8) | Memory operand |
| cIn | input | 1 | Incoming carry flag |
| zIn | input | 1 | Incoming zero flag |
| nIn | input | 1 | Incoming negative flag |
| vIn | input | 1 | Incoming overflow flag |
| dIn | input | 1 | Decimal mode flag |
| resultOut | output | WIDTH (8) | Registered result |
| cOut | output | 1 | Updated carry flag |
| zOut | output | 1 | Updated zero flag |
| nOut | output | 1 | Updated negative flag |
| vOut | output | 1 | Updated overflow flag |
| doneOut | output | 1 | Result registered from a valid operation |
| extraOut | output | 1 | Decimal arithmetic needs one more cycle |

## Verification
The properties compare registered outputs with `$past` of the inputs seen at the previous edge. They therefore assume every input, `opSel` included, is steady and known across each rising edge. The bench honours this by changing inputs only on falling edges. Decimal results are defined only for operands whose nibbles are 0–9. The checks and the stimulus on the decimal path keep to such operands, while the properties on that path constrain only V and the extra-cycle strobe.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CMP  = 4'd11,
    OP_TCLR = 4'd12,
    OP_TSET = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    U_PASS,
    U_ARITH,
    U_LOGIC,
    U_SHIFT,
    U_STEP,
    U_BITS
  } unit_e;

  typedef enum logic [1:0] {
    L_AND,
    L_OR,
    L_XOR
  } logicFn_e;

  // control-to-datapath strobes
  typedef struct packed {
    unit_e    unit;
    logic     subtract;    // invert operand, carry means no-borrow
    logic     decimal;     // use BCD digit slices
    logic     forceCarry;  // compare: subtract with no borrow in
    logic     keepAcc;     // result port returns accumulator
    logicFn_e logicFn;
    logic     shiftRight;
    logic     rotate;      // carry enters vacated bit
    logic     stepDown;
    logic     bitSet;
    logic     updC;
    logic     updV;
    logic     updNZ;
    logic     nvFromMem;   // N,V from top bits of operand
  } aluStrobe_t;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } aluFlags_t;

endpackage

// File: rtl/alu_bcd_digit.sv
// One decimal digit of add/subtract. carryIn/carryOut use the binary
// convention: 1 = carry for add, 1 = no borrow for subtract.
module alu_bcd_digit (
  input  logic       subtract,
  input  logic [3:0] aDig,
  input  logic [3:0] mDig,
  input  logic       carryIn,
  output logic [3:0] digOut,
  output logic       carryOut
);
  logic [4:0] addRaw;
  logic [4:0] subRaw;

  always_comb begin
    addRaw = {1'b0, aDig} + {1'b0, mDig} + {4'b0, carryIn};
    subRaw = {1'b0, aDig} - {1'b0, mDig} - {4'b0, ~carryIn};
    if (!subtract) begin
      if (addRaw > 5'd9) begin
        digOut   = addRaw[3:0] + 4'd6;
        carryOut = 1'b1;
      end else begin
        digOut   = addRaw[3:0];
        carryOut = 1'b0;
      end
    end else begin
      if (subRaw[4]) begin
        digOut   = subRaw[3:0] - 4'd6;
        carryOut = 1'b0;
      end else begin
        digOut   = subRaw[3:0];
        carryOut = 1'b1;
      end
    end
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opSel,
  input  logic       dIn,
  output aluStrobe_t strobe,
  output logic       doneOut,
  output logic       extraOut
);

  always_comb begin
    strobe         = '0;
    strobe.unit    = U_PASS;
    strobe.logicFn = L_AND;
    case (aluOp_e'(opSel))
      OP_ADD: begin
        strobe.unit    = U_ARITH;
        strobe.decimal = dIn;
        strobe.updC    = 1'b1;
        strobe.updV    = ~dIn;
        strobe.updNZ   = 1'b1;
      end
      OP_SUB: begin
        strobe.unit     = U_ARITH;
        strobe.subtract = 1'b1;
        strobe.decimal  = dIn;
        strobe.updC     = 1'b1;
        strobe.updV     = ~dIn;
        strobe.updNZ    = 1'b1;
      end
      OP_CMP: begin
        strobe.unit       = U_ARITH;
        strobe.subtract   = 1'b1;
        strobe.forceCarry = 1'b1;
        strobe.keepAcc    = 1'b1;
        strobe.updC       = 1'b1;
        strobe.updNZ      = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobe.unit    = U_LOGIC;
        strobe.updNZ   = 1'b1;
        strobe.logicFn = (opSel == OP_AND) ? L_AND :
                         (opSel == OP_OR)  ? L_OR  : L_XOR;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        strobe.unit       = U_SHIFT;
        strobe.shiftRight = (opSel == OP_SHR) || (opSel == OP_ROR);
        strobe.rotate     = (opSel == OP_ROL) || (opSel == OP_ROR);
        strobe.updC       = 1'b1;
        strobe.updNZ      = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobe.unit     = U_STEP;
        strobe.stepDown = (opSel == OP_DEC);
        strobe.updNZ    = 1'b1;
      end
      OP_TCLR, OP_TSET: begin
        strobe.unit      = U_BITS;
        strobe.bitSet    = (opSel == OP_TSET);
        strobe.updNZ     = 1'b1;
        strobe.nvFromMem = 1'b1;
      end
      default: begin
        strobe.unit = U_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOut  <= 1'b0;
      extraOut <= 1'b0;
    end else begin
      doneOut  <= opValid;
      extraOut <= opValid && (strobe.unit == U_ARITH) && strobe.decimal;
    end
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] memIn,
  input  aluFlags_t        flagsIn,
  output logic [WIDTH-1:0] resultOut,
  output aluFlags_t        flagsOut
);
  localparam int DIGITS = WIDTH / 4;
  localparam int MSB    = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] operB;
  logic             carryIn;
  logic [WIDTH:0]   binSum;
  logic             binV;
  logic [WIDTH-1:0] bcdSum;
  logic [DIGITS:0]  digCarry;

  logic [WIDTH-1:0] rawRes;
  logic             newC;
  logic             shiftIn;
  logic [WIDTH-1:0] resNext;
  aluFlags_t        flagsNext;

  // shared binary adder: subtract adds the inverted operand
  always_comb begin
    operB   = strobe.subtract ? ~memIn : memIn;
    carryIn = strobe.forceCarry | flagsIn.c;
    binSum  = {1'b0, accIn} + {1'b0, operB} + {{WIDTH{1'b0}}, carryIn};
    binV    = (accIn[MSB] == operB[MSB]) && (binSum[MSB] != accIn[MSB]);
  end

  // decimal path: ripple of per-digit corrected slices
  assign digCarry[0] = carryIn;
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    alu_bcd_digit u_dig (
      .subtract (strobe.subtract),
      .aDig     (accIn[4*g +: 4]),
      .mDig     (memIn[4*g +: 4]),
      .carryIn  (digCarry[g]),
      .digOut   (bcdSum[4*g +: 4]),
      .carryOut (digCarry[g+1])
    );
  end

  always_comb begin
    rawRes  = accIn;
    newC    = flagsIn.c;
    shiftIn = strobe.rotate & flagsIn.c;
    case (strobe.unit)
      U_ARITH: begin
        rawRes = strobe.decimal ? bcdSum : binSum[MSB:0];
        newC   = strobe.decimal ? digCarry[DIGITS] : binSum[WIDTH];
      end
      U_LOGIC: begin
        case (strobe.logicFn)
          L_AND:   rawRes = accIn & memIn;
          L_OR:    rawRes = accIn | memIn;
          default: rawRes = accIn ^ memIn;
        endcase
      end
      U_SHIFT: begin
        if (strobe.shiftRight) begin
          rawRes = {shiftIn, accIn[MSB:1]};
          newC   = accIn[0];
        end else begin
          rawRes = {accIn[MSB-1:0], shiftIn};
          newC   = accIn[MSB];
        end
      end
      U_STEP: begin
        rawRes = strobe.stepDown ? (accIn - ONE) : (accIn + ONE);
      end
      U_BITS: begin
        rawRes = strobe.bitSet ? (memIn | accIn) : (memIn & ~accIn);
      end
      default: rawRes = accIn;
    endcase

    resNext     = strobe.keepAcc ? accIn : rawRes;
    flagsNext.c = strobe.updC ? newC : flagsIn.c;
    flagsNext.v = strobe.nvFromMem ? memIn[MSB-1] :
                  (strobe.updV ? binV : flagsIn.v);
    flagsNext.z = strobe.updNZ ? (rawRes == '0) : flagsIn.z;
    flagsNext.n = strobe.updNZ ? (strobe.nvFromMem ? memIn[MSB] : rawRes[MSB])
                               : flagsIn.n;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (opValid) begin
      resultOut <= resNext;
      flagsOut  <= flagsNext;
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] memIn,
  input  logic             cIn,
  input  logic             zIn,
  input  logic             nIn,
  input  logic             vIn,
  input  logic             dIn,
  output logic [WIDTH-1:0] resultOut,
  output logic             cOut,
  output logic             zOut,
  output logic             nOut,
  output logic             vOut,
  output logic             doneOut,
  output logic             extraOut
);
  aluStrobe_t strobe;
  aluFlags_t  flagsInS;
  aluFlags_t  flagsOutS;

  assign flagsInS = '{c: cIn, z: zIn, n: nIn, v: vIn};

  alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opSel    (opSel),
    .dIn      (dIn),
    .strobe   (strobe),
    .doneOut  (doneOut),
    .extraOut (extraOut)
  );

  alu_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .strobe    (strobe),
    .accIn     (accIn),
    .memIn     (memIn),
    .flagsIn   (flagsInS),
    .resultOut (resultOut),
    .flagsOut  (flagsOutS)
  );

  assign cOut = flagsOutS.c;
  assign zOut = flagsOutS.z;
  assign nOut = flagsOutS.n;
  assign vOut = flagsOutS.v;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] accIn,
  input logic [WIDTH-1:0] memIn,
  input logic             cIn,
  input logic             zIn,
  input logic             nIn,
  input logic             vIn,
  input logic             dIn,
  input logic [WIDTH-1:0] resultOut,
  input logic             cOut,
  input logic             zOut,
  input logic             nOut,
  input logic             vOut,
  input logic             doneOut,
  input logic             extraOut
);
  logic isArith;
  logic isLogic;
  logic isStep;
  logic isBits;
  assign isArith = (opSel == 4'd0) || (opSel == 4'd1);
  assign isLogic = (opSel == 4'd2) || (opSel == 4'd3) || (opSel == 4'd4);
  assign isStep  = (opSel == 4'd9) || (opSel == 4'd10);
  assign isBits  = (opSel == 4'd12) || (opSel == 4'd13);

  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!doneOut && !extraOut);
    end
  end

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> doneOut);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !doneOut && $stable(resultOut) && $stable(cOut) &&
                 $stable(zOut) && $stable(nOut) && $stable(vOut));

  p_dec_keeps_v_r5: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isArith && dIn |=> vOut == $past(vIn));

  p_extra_raise_r6: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isArith && dIn |=> extraOut && doneOut);

  p_extra_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && isArith && dIn) |=> !extraOut);

  p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isLogic |=> cOut == $past(cIn) && vOut == $past(vIn));

  p_step_keeps_cv_r9: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isStep |=> cOut == $past(cIn) && vOut == $past(vIn));

  p_cmp_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opSel == 4'd11) |=> resultOut == $past(accIn) && vOut == $past(vIn));

  p_bits_nv_r11: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isBits |=> nOut == $past(memIn[WIDTH-1]) &&
                          vOut == $past(memIn[WIDTH-2]) && cOut == $past(cIn));

  p_reserved_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opSel >= 4'd14) |=> resultOut == $past(accIn) &&
      cOut == $past(cIn) && zOut == $past(zIn) && nOut == $past(nIn) &&
      vOut == $past(vIn));
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .accIn     (accIn),
  .memIn     (memIn),
  .cIn       (cIn),
  .zIn       (zIn),
  .nIn       (nIn),
  .vIn       (vIn),
  .dIn       (dIn),
  .resultOut (resultOut),
  .cOut      (cOut),
  .zOut      (zOut),
  .nOut      (nOut),
  .vOut      (vOut),
  .doneOut   (doneOut),
  .extraOut  (extraOut)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opSel = 4'd0;
  logic [7:0] accIn = 8'h00;
  logic [7:0] memIn = 8'h00;
  logic       cIn = 1'b0, zIn = 1'b0, nIn = 1'b0, vIn = 1'b0, dIn = 1'b0;
  logic [7:0] resultOut;
  logic       cOut, zOut, nOut, vOut, doneOut, extraOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;

  alu_core #(.WIDTH(8)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .memIn(memIn), .cIn(cIn), .zIn(zIn), .nIn(nIn),
    .vIn(vIn), .dIn(dIn), .resultOut(resultOut), .cOut(cOut),
    .zOut(zOut), .nOut(nOut), .vOut(vOut), .doneOut(doneOut),
    .extraOut(extraOut)
  );

  function automatic int bcdToInt(logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] intToBcd(int t);
    logic [3:0] hi, lo;
    hi = 4'((t / 10) % 10);
    lo = 4'(t % 10);
    return {hi, lo};
  endfunction

  // independent reference: returns {result, c, z, n, v}
  function automatic logic [11:0] refOp(logic [3:0] op, logic [7:0] a, logic [7:0] m,
                                        logic c, logic z, logic n, logic v, logic d);
    logic [7:0] r;
    logic nc, nz, nn, nv;
    int t, s;
    r = a; nc = c; nz = z; nn = n; nv = v;
    case (op)
      4'd0: begin
        if (d) begin
          t = bcdToInt(a) + bcdToInt(m) + int'(c);
          nc = (t > 99); r = intToBcd(t % 100);
        end else begin
          t = int'(a) + int'(m) + int'(c);
          nc = (t > 255); r = 8'(t);
          s = int'($signed(a)) + int'($signed(m)) + int'(c);
          nv = (s > 127) || (s < -128);
        end
      end
      4'd1: begin
        if (d) begin
          t = bcdToInt(a) - bcdToInt(m) - (1 - int'(c));
          nc = (t >= 0); if (t < 0) t = t + 100; r = intToBcd(t);
        end else begin
          t = int'(a) - int'(m) - (1 - int'(c));
          nc = (t >= 0); r = 8'(t);
          s = int'($signed(a)) - int'($signed(m)) - (1 - int'(c));
          nv = (s > 127) || (s < -128);
        end
      end
      4'd2: r = a & m;
      4'd3: r = a | m;
      4'd4: r = a ^ m;
      4'd5: begin r = 8'(int'(a) * 2); nc = (a >= 8'd128); end
      4'd6: begin r = a / 2; nc = a[0]; end
      4'd7: begin r = 8'(int'(a) * 2 + int'(c)); nc = (a >= 8'd128); end
      4'd8: begin r = 8'(int'(a) / 2 + int'(c) * 128); nc = a[0]; end
      4'd9: r = 8'(int'(a) + 1);
      4'd10: r = 8'(int'(a) + 255);
      4'd11: r = a;
      4'd12: r = m & ~a;
      4'd13: r = m | a;
      default: r = a;
    endcase
    if (op <= 4'd10 || op == 4'd12 || op == 4'd13) begin
      nz = (r == 8'd0);
      nn = (r >= 8'd128);
    end
    if (op == 4'd11) begin
      t = int'(a) - int'(m);
      nc = (a >= m);
      nz = (t == 0);
      nn = (8'(t) >= 8'd128);
    end
    if (op == 4'd12 || op == 4'd13) begin
      nn = m[7];
      nv = m[6];
    end
    return {r, nc, nz, nn, nv};
  endfunction

  task automatic check(string tag, logic [13:0] got, logic [13:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge with opValid low
  task automatic runCheck(string tag, logic [3:0] op, logic [7:0] a, logic [7:0] m,
                          logic c, logic z, logic n, logic v, logic d);
    logic [11:0] e;
    opValid = 1'b1; opSel = op; accIn = a; memIn = m;
    cIn = c; zIn = z; nIn = n; vIn = v; dIn = d;
    @(negedge clk);
    opValid = 1'b0;
    e = refOp(op, a, m, c, z, n, v, d);
    check(tag, {resultOut, cOut, zOut, nOut, vOut, doneOut, extraOut},
          {e, 1'b1, (op <= 4'd1) && d});
  endtask

  task automatic testReset();
    rstN = 1'b0;
    opValid = 1'b1; opSel = 4'd0; accIn = 8'hFF; memIn = 8'h01; cIn = 1'b1; dIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {resultOut, cOut, zOut, nOut, vOut, doneOut, extraOut}, 14'h0);
    opValid = 1'b0; dIn = 1'b0; cIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", {resultOut, cOut, zOut, nOut, vOut, doneOut, extraOut}, 14'h0);
  endtask

  task automatic testHold();
    runCheck("R2 single op", 4'd0, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    accIn = 8'hAA; memIn = 8'h55; opSel = 4'd1; cIn = 1'b1; vIn = 1'b1; dIn = 1'b1;
    @(negedge clk);
    check("R2 idle hold", {resultOut, cOut, zOut, nOut, vOut, doneOut, extraOut},
          {8'h46, 4'b0000, 2'b00});
    opValid = 1'b1; opSel = 4'd9; accIn = 8'h01; dIn = 1'b0; cIn = 1'b0; vIn = 1'b0;
    @(negedge clk);
    check("R2 back-to-back first", {resultOut, doneOut}, {8'h02, 1'b1});
    opSel = 4'd9; accIn = 8'h7F;
    @(negedge clk);
    opValid = 1'b0;
    check("R2 back-to-back second", {resultOut, nOut, doneOut}, {8'h80, 1'b1, 1'b1});
  endtask

  task automatic testAdd();
    runCheck("R3 add plain",      4'd0, 8'h10, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    runCheck("R3 add carry wrap", 4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R3 add pos ovf",    4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R3 add neg ovf",    4'd0, 8'h80, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R3 add carry in",   4'd0, 8'h3C, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testSub();
    runCheck("R4 sub plain",     4'd1, 8'h50, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runCheck("R4 sub borrow",    4'd1, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R4 sub ovf",       4'd1, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R4 sub borrow in", 4'd1, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R4 sub to zero",   4'd1, 8'h33, 8'h33, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testDecimal();
    runCheck("R5 R6 dec add",      4'd0, 8'h15, 8'h27, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    runCheck("R5 R6 dec add wrap", 4'd0, 8'h99, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    runCheck("R5 dec add cin",     4'd0, 8'h58, 8'h46, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    runCheck("R5 R6 dec sub",      4'd1, 8'h42, 8'h15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    runCheck("R5 dec sub borrow",  4'd1, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    runCheck("R6 no extra logic d", 4'd2, 8'h0F, 8'h35, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testLogic();
    runCheck("R7 and", 4'd2, 8'hF0, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runCheck("R7 or",  4'd3, 8'h80, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCheck("R7 xor zero", 4'd4, 8'hA5, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testShift();
    runCheck("R8 shl",        4'd5, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runCheck("R8 shr",        4'd6, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    runCheck("R8 rol cin",    4'd7, 8'h40, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R8 ror cin",    4'd8, 8'h02, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runCheck("R8 ror no cin", 4'd8, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testIncDec();
    runCheck("R9 inc wrap", 4'd9,  8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    runCheck("R9 dec wrap", 4'd10, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runCheck("R9 dec one",  4'd10, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testCompare();
    runCheck("R10 cmp equal", 4'd11, 8'h40, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    runCheck("R10 cmp less",  4'd11, 8'h10, 8'h20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    runCheck("R10 cmp more",  4'd11, 8'h20, 8'h10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testBits();
    runCheck("R11 clear bits", 4'd12, 8'h0F, 8'hCF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runCheck("R11 clear zero", 4'd12, 8'hFF, 8'h4F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    runCheck("R11 set bits",   4'd13, 8'h01, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testReserved();
    runCheck("R12 code 14", 4'd14, 8'h5A, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    runCheck("R12 code 15", 4'd15, 8'h00, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL R2 watchdog expired: actual=running expected=done");
    finish();
  end

  initial begin
    @(negedge clk);
    testReset();
    testHold();
    testAdd();
    testSub();
    testDecimal();
    testLogic();
    testShift();
    testIncDec();
    testCompare();
    testBits();
    testReserved();
    repeat (2) @(negedge clk);
    finish();
  end
endmodule